// File: doc/BRIEF.md
# Jam-Loaded Serial-Out Shift Register

The block is an eight-stage shift register. Each stage can be filled at once from its own parallel input (a "jam"), or the whole register can shift data in from a single serial input. One mode input chooses between the two. When the mode is low, every rising clock edge moves the contents one stage toward the output end and brings in the serial bit. When the mode is high, the parallel word is entered instead. The last three stages are brought out as taps, and the final stage is the main serial output.

A compile-time parameter picks the jam style. In the clocked style, the parallel word is captured on the rising edge while the mode is high. In the clock-free style, the stages take the parallel word as soon as the mode is high and keep following it while the mode stays high, and clock edges have no effect during that time. Shifting is always clocked. Longer registers are built by connecting the serial output of one instance to the serial input of the next, with the clock and mode shared between them. An active-low asynchronous reset clears every stage.

The mode input is decoded into two named modes, `MODE_SHIFT` (mode input 0) and `MODE_JAM` (mode input 1). The transition `MODE_SHIFT -> MODE_JAM` takes place when the mode input rises, and `MODE_JAM -> MODE_SHIFT` when it falls. Neither mode holds any state of its own.

Top module: `piso_jam_shifter`

## Requirements
- R1: While `rst_n` is 0, all stages are 0, so `tap_n2`, `tap_n1` and `ser_out` are 0. Asserting the reset clears the stages at once, without waiting for a clock edge.
- R2: With `load_sel` = 0, each rising edge of `clk` loads `ser_in` into stage 1 and the old value of stage k-1 into stage k, for k = 2..8.
- R3: With `ASYNC_LOAD` = 0 and `load_sel` = 1, each rising edge loads `par_in[k-1]` into stage k. So `par_in[0]` goes to stage 1, next to the serial input, and `par_in[7]` goes to stage 8, the output end.
- R4: With `ASYNC_LOAD` = 0, a change of `par_in` between clock edges does not change any output until the next rising edge.
- R5: With `ASYNC_LOAD` = 1 and `load_sel` = 1, stage k equals `par_in[k-1]` in the same time step as any change of `load_sel` or `par_in`, with no clock edge.
- R6: With `ASYNC_LOAD` = 1, a rising clock edge while `load_sel` = 1 does not shift. The stages keep following `par_in`, whatever the value of `ser_in`.
- R7: With `ASYNC_LOAD` = 1, after `load_sel` falls the stages hold the last jammed word, and `par_in` no longer has any effect. Shifting starts again on the first rising edge after the fall.
- R8: `tap_n2`, `tap_n1` and `ser_out` show stages 6, 7 and 8. After a jam of word P followed by shifts, `ser_out` gives P[7], P[6], ..., P[0], one bit per rising edge.
- R9: When two instances are chained (`ser_out` of the first into `ser_in` of the second, with `clk`, `rst_n` and `load_sel` shared), a jam of A into the first and B into the second followed by shifts makes the second `ser_out` give B[7..0] and then A[7..0], 16 bits in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and clocked-jam clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| load_sel | input | 1 | Mode input: 0 shifts (MODE_SHIFT), 1 jams the parallel word (MODE_JAM) |
| ser_in | input | 1 | Serial data into stage 1 |
| par_in | input | STAGES (8) | Parallel jam word; bit k-1 goes to stage k |
| tap_n2 | output | 1 | Stage 6 (third from the end) |
| tap_n1 | output | 1 | Stage 7 (second from the end) |
| ser_out | output | 1 | Stage 8, the serial output and cascade link |

## Verification
Shifts and clocked jams are due one rising edge after the inputs that cause them. Inputs are driven 2 ns after a falling edge, so they are stable at the rising edge, and every output is compared at the next falling edge against a behavioural queue model. A clock-free jam is due in the same time step as its trigger, so those checks sample 1 ns after a mid-cycle change of `par_in` or `load_sel`. Checks that the outputs hold their value (clocked-style `par_in` changes, and `par_in` after the clock-free jam ends) are made in the middle of the cycle, before the next rising edge. The serial order is checked bit by bit on the falling edge after each shift, for one register and for a chain of two.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_JAM   = 1'b1
    } piso_mode_e;

    localparam int unsigned TAP_COUNT = 3;

endpackage

// File: rtl/piso_mode_dec.sv
module piso_mode_dec
    import piso_pkg::*;
(
    input  logic       load_sel,
    output piso_mode_e mode
);

    always_comb begin
        mode = MODE_SHIFT;
        unique case (load_sel)
            1'b1: mode = MODE_JAM;
            1'b0: mode = MODE_SHIFT;
        endcase
    end

endmodule

// File: rtl/piso_stage.sv
module piso_stage
    import piso_pkg::*;
#(
    parameter bit ASYNC_LOAD = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  piso_mode_e mode,
    input  logic       jam_d,
    input  logic       shift_d,
    output logic       q
);

    logic q_r;

    generate
        if (ASYNC_LOAD) begin : g_async
            // The jam drives the flop's asynchronous set or clear, so the
            // clock is ignored while the jam is active.
            logic force_one;
            logic force_zero;

            assign force_one  = rst_n & (mode == MODE_JAM) & jam_d;
            assign force_zero = ~rst_n | ((mode == MODE_JAM) & ~jam_d);

            always_ff @(posedge clk or posedge force_zero or posedge force_one) begin
                if (force_zero) begin
                    q_r <= 1'b0;
                end else if (force_one) begin
                    q_r <= 1'b1;
                end else begin
                    q_r <= shift_d;
                end
            end
        end else begin : g_sync
            logic next_d;

            always_comb begin
                next_d = shift_d;
                unique case (mode)
                    MODE_JAM:   next_d = jam_d;
                    MODE_SHIFT: next_d = shift_d;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_r <= 1'b0;
                end else begin
                    q_r <= next_d;
                end
            end
        end
    endgenerate

    assign q = q_r;

endmodule

// File: rtl/piso_tap_sel.sv
module piso_tap_sel #(
    parameter int unsigned STAGES = 8
) (
    input  logic [STAGES-1:0] stg,
    output logic              tap_n2,
    output logic              tap_n1,
    output logic              ser_out
);

    localparam int unsigned LAST = STAGES - 1;

    assign tap_n2  = stg[LAST-2];
    assign tap_n1  = stg[LAST-1];
    assign ser_out = stg[LAST];

endmodule

// File: rtl/piso_jam_shifter.sv
module piso_jam_shifter
    import piso_pkg::*;
#(
    parameter int unsigned STAGES     = 8,
    parameter bit          ASYNC_LOAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_sel,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              tap_n2,
    output logic              tap_n1,
    output logic              ser_out
);

    localparam int unsigned MIN_STAGES = TAP_COUNT;

    initial begin
        if (STAGES < MIN_STAGES) begin
            $error("STAGES must cover the three output taps");
        end
    end

    piso_mode_e        mode;
    logic [STAGES-1:0] stg;
    logic [STAGES-1:0] shift_src;

    piso_mode_dec u_mode (
        .load_sel (load_sel),
        .mode     (mode)
    );

    // Stage 1 (index 0) takes the serial input; stage k takes stage k-1.
    assign shift_src = {stg[STAGES-2:0], ser_in};

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            piso_stage #(
                .ASYNC_LOAD (ASYNC_LOAD)
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .mode    (mode),
                .jam_d   (par_in[k]),
                .shift_d (shift_src[k]),
                .q       (stg[k])
            );
        end
    endgenerate

    piso_tap_sel #(
        .STAGES (STAGES)
    ) u_taps (
        .stg     (stg),
        .tap_n2  (tap_n2),
        .tap_n1  (tap_n1),
        .ser_out (ser_out)
    );

endmodule

// File: rtl/piso_jam_shifter_chk.sv
module piso_jam_shifter_chk #(
    parameter int unsigned STAGES     = 8,
    parameter bit          ASYNC_LOAD = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_sel,
    input logic              ser_in,
    input logic [STAGES-1:0] par_in,
    input logic              tap_n2,
    input logic              tap_n1,
    input logic              ser_out,
    input logic [STAGES-1:0] stg
);

    // R1: reset holds every stage at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (stg == '0));

    // R2: the serial bit enters stage 1
    a_r2_serial_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !load_sel |=> ((ASYNC_LOAD && load_sel) || (stg[0] == $past(ser_in))));

    // R2: each stage takes its neighbour's old value
    a_r2_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !load_sel |=> ((ASYNC_LOAD && load_sel) ||
                       (stg[STAGES-1:1] == $past(stg[STAGES-2:0]))));

    // R8: the taps pass bits toward the output one edge apart
    a_r8_tap_relay: assert property (@(posedge clk) disable iff (!rst_n)
        !load_sel |=> ((ASYNC_LOAD && load_sel) ||
                       ((ser_out == $past(tap_n1)) && (tap_n1 == $past(tap_n2)))));

    generate
        if (ASYNC_LOAD) begin : g_async_chk
            // R5, R6: while jamming, the stages match the parallel word at every edge
            a_r5_async_follow: assert property (@(posedge clk) disable iff (!rst_n)
                load_sel |-> (stg == par_in));
        end else begin : g_sync_chk
            // R3: a clocked jam captures the parallel word
            a_r3_sync_capture: assert property (@(posedge clk) disable iff (!rst_n)
                load_sel |=> (stg == $past(par_in)));
        end
    endgenerate

endmodule

bind piso_jam_shifter piso_jam_shifter_chk #(
    .STAGES     (STAGES),
    .ASYNC_LOAD (ASYNC_LOAD)
) u_chk (.*);

// File: tb/test_piso_jam_shifter.sv
module test_piso_jam_shifter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel = 1'b0;
    logic       sin = 1'b0;
    logic [7:0] pin = 8'h00;
    logic [7:0] pin_lo = 8'h00;
    logic [7:0] pin_hi = 8'h00;

    logic s_n2, s_n1, s_out;
    logic a_n2, a_n1, a_out;
    logic c_mid, c0_n2, c0_n1, c_n2, c_n1, c_out;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    bit ms[$];
    bit ma[$];
    bit mc[$];

    always #10 clk = ~clk;

    piso_jam_shifter #(.STAGES(8), .ASYNC_LOAD(1'b0)) i_piso_jam_shifter (
        .clk(clk), .rst_n(rst_n), .load_sel(sel), .ser_in(sin), .par_in(pin),
        .tap_n2(s_n2), .tap_n1(s_n1), .ser_out(s_out));

    piso_jam_shifter #(.STAGES(8), .ASYNC_LOAD(1'b1)) i_async (
        .clk(clk), .rst_n(rst_n), .load_sel(sel), .ser_in(sin), .par_in(pin),
        .tap_n2(a_n2), .tap_n1(a_n1), .ser_out(a_out));

    piso_jam_shifter #(.STAGES(8), .ASYNC_LOAD(1'b0)) i_casc_first (
        .clk(clk), .rst_n(rst_n), .load_sel(sel), .ser_in(sin), .par_in(pin_lo),
        .tap_n2(c0_n2), .tap_n1(c0_n1), .ser_out(c_mid));

    piso_jam_shifter #(.STAGES(8), .ASYNC_LOAD(1'b0)) i_casc_second (
        .clk(clk), .rst_n(rst_n), .load_sel(sel), .ser_in(c_mid), .par_in(pin_hi),
        .tap_n2(c_n2), .tap_n1(c_n1), .ser_out(c_out));

    // Reference model: queue index 0 is stage 1.
    initial begin
        for (int k = 0; k < 8; k++) begin ms.push_back(1'b0); ma.push_back(1'b0); end
        for (int k = 0; k < 16; k++) mc.push_back(1'b0);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (ms[k]) ms[k] = 1'b0;
            foreach (ma[k]) ma[k] = 1'b0;
            foreach (mc[k]) mc[k] = 1'b0;
        end else if (sel) begin
            for (int k = 0; k < 8; k++) begin
                ms[k] = pin[k];
                mc[k] = pin_lo[k];
                mc[k+8] = pin_hi[k];
            end
        end else begin
            ms.push_front(sin); void'(ms.pop_back());
            ma.push_front(sin); void'(ma.pop_back());
            mc.push_front(sin); void'(mc.pop_back());
        end
    end

    always @(sel or pin or rst_n) begin
        if (rst_n && sel) begin
            for (int k = 0; k < 8; k++) ma[k] = pin[k];
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input string req);
        chk(req, "sync tap_n2", s_n2, ms[5]);
        chk(req, "sync tap_n1", s_n1, ms[6]);
        chk(req, "sync ser_out", s_out, ms[7]);
        chk(req, "async tap_n2", a_n2, ma[5]);
        chk(req, "async tap_n1", a_n1, ma[6]);
        chk(req, "async ser_out", a_out, ma[7]);
        chk(req, "cascade link", c_mid, mc[7]);
        chk(req, "cascade tap_n2", c_n2, mc[13]);
        chk(req, "cascade tap_n1", c_n1, mc[14]);
        chk(req, "cascade ser_out", c_out, mc[15]);
    endtask

    always @(negedge clk) cmp_all(cur_req);

    task automatic drive(input logic s, input logic d, input logic [7:0] p);
        @(negedge clk);
        #2;
        sel = s; sin = d; pin = p;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end in time");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] pat;
        logic [2:0] held;
        logic [7:0] a_word;
        logic [7:0] b_word;
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "ser_out in reset", s_out, 1'b0);
        chk("R1", "async ser_out in reset", a_out, 1'b0);
        #2 rst_n = 1'b1;

        // R2: serial pattern through all stages
        cur_req = "R2";
        pat = 8'b1011_0011;
        for (int k = 0; k < 10; k++) drive(1'b0, pat[k % 8], 8'h00);
        for (int k = 0; k < 8; k++) drive(1'b0, 1'b1, 8'h00);
        @(negedge clk);
        chk("R2", "all-ones fill tap_n2", s_n2, 1'b1);
        chk("R2", "all-ones fill ser_out", a_out, 1'b1);

        // R3, R8: jam then serial order on both styles
        foreach (pat[k]) pat[k] = 1'b0;
        for (int w = 0; w < 2; w++) begin
            pat = (w == 0) ? 8'hB4 : 8'h5A;
            cur_req = "R3";
            drive(1'b1, 1'b0, pat);
            cur_req = "R8";
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                chk("R8", "sync serial order", s_out, pat[7-k]);
                chk("R8", "async serial order", a_out, pat[7-k]);
                #2;
                sel = 1'b0; sin = 1'b0;
            end
        end

        // R4, R5: mid-cycle parallel changes
        cur_req = "R4";
        drive(1'b1, 1'b0, 8'h0F);
        @(negedge clk);
        #2;
        sel = 1'b1; pin = 8'hF0;
        held = {s_n2, s_n1, s_out};
        #1;
        chk("R5", "async ser_out follows jam", a_out, 1'b1);
        #5;
        pin = 8'h3C;
        #1;
        chk("R4", "sync taps unchanged mid-cycle", ({s_n2, s_n1, s_out} == held), 1'b1);
        chk("R5", "async tap_n2 follows", a_n2, 1'b1);
        chk("R5", "async tap_n1 follows", a_n1, 1'b0);
        chk("R5", "async ser_out follows", a_out, 1'b0);

        // R6: edges with the jam held do not shift
        cur_req = "R6";
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, k[0], 8'h3C);
            @(posedge clk);
            #3;
            chk("R6", "async tap_n2 after edge", a_n2, 1'b1);
            chk("R6", "async ser_out after edge", a_out, 1'b0);
        end

        // R7: jam released, hold, then shift
        cur_req = "R7";
        @(negedge clk);
        #2;
        sel = 1'b0; sin = 1'b1;
        #1;
        pin = 8'h00;
        #1;
        chk("R7", "async tap_n2 holds after release", a_n2, 1'b1);
        chk("R7", "async tap_n1 holds after release", a_n1, 1'b0);
        @(negedge clk);
        chk("R7", "async tap_n1 after first shift", a_n1, 1'b1);
        chk("R7", "async ser_out after first shift", a_out, 1'b0);

        // R9: two-instance chain gives 16 bits
        cur_req = "R9";
        a_word = 8'hC5;
        b_word = 8'h6A;
        pin_lo = a_word;
        pin_hi = b_word;
        drive(1'b1, 1'b0, 8'h00);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chk("R9", "cascade serial order", c_out, (k < 8) ? b_word[7-k] : a_word[15-k]);
            #2;
            sel = 1'b0; sin = 1'b0;
        end

        // R1: asynchronous clear in the middle of a cycle
        cur_req = "R1";
        drive(1'b1, 1'b0, 8'hFF);
        @(negedge clk);
        #2;
        sel = 1'b0;
        #3;
        rst_n = 1'b0;
        #1;
        chk("R1", "sync ser_out cleared at once", s_out, 1'b0);
        chk("R1", "async tap_n2 cleared at once", a_n2, 1'b0);
        chk("R1", "cascade ser_out cleared at once", c_out, 1'b0);
        @(negedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule